// File: doc/BRIEF.md
# Debug Port Serial Shifter

This block links an external debug tool to a processor core over a three-wire synchronous serial link. The tool supplies a serial clock that has no phase relation to the system clock, a serial data input and reads a serial data output. On the core side, a fetch from the instruction pseudo-register or a read or write of the data pseudo-register is a single access request. Every kind of access is served by the same shift register.

After the core makes a request, the request word crosses into the serial-clock domain, and the port raises a ready bit on the output line. The tool answers with a frame: start bit, mode bit, control bit, then a 7-bit or 32-bit payload, most significant bit first. While the frame comes in, the port shifts two status bits and then the response payload out, full duplex. The completed word crosses back to the system-clock domain. It is delivered with a one-cycle done pulse, and a sequence-error flag is raised if its kind does not match what the core asked for.

Core-side states: `CORE_IDLE` goes to `CORE_WAIT` on an accepted request, and `CORE_WAIT` returns to `CORE_IDLE` when the response toggle arrives. Serial-side states: `SER_IDLE` goes to `SER_READY` when a new request toggle is seen. `SER_READY` goes to `SER_MODE` when a start bit (1) is sampled. `SER_MODE` always goes to `SER_CTRL`, and `SER_CTRL` always goes to `SER_DATA`. `SER_DATA` returns to `SER_IDLE` after the last payload bit.

Top module: `dbgp_port`

## Requirements
- R1: After reset, `sdo`, `busy`, `done` and `seq_err` are all 0.
- R2: While no core request is outstanding, `sdo` stays 0 and `sdi` activity produces no frame. After a request, `sdo` goes to 1 (ready) within a few serial clocks and holds 1 until a start bit of 1 is sampled.
- R3: A frame is start (1), mode, control, payload MSB first. Mode 0 means a 32-bit payload and mode 1 means a 7-bit payload. The received payload appears on `rx_word`, zero-extended.
- R4: `sdo` changes on the falling edge of `sck`. The first status bit is presented for the mode-bit rising edge, the second for the control-bit edge, and response bits MSB first for each payload edge. The response is `acc_wdata` (low 7 bits for a 7-bit frame) for a write, and zero otherwise.
- R5: The status code (first bit, second bit) is 01 if the previous frame had a sequence error. Otherwise it is 10 if `irq_pend` was high at the request. Otherwise it is 00 for a data write and 11 for a fetch or data read.
- R6: Each completed frame gives exactly one single-cycle `done` pulse with `rx_kind` = 0 for an instruction (mode 0, control 0), 1 for data (mode 0, control 1), 2 for a 7-bit command.
- R7: `seq_err` is high with `done` when a 32-bit frame's kind mismatches the request. A fetch (`acc_kind` 0) expects an instruction, and a data read (1) or write (2, 3) expects data. Command frames never raise it.
- R8: An `acc_req` while `busy` is high is ignored and does not alter the outstanding response word.
- R9: `busy` is high from the cycle after an accepted request until the cycle `done` pulses. After the frame, `sdo` returns to 0 and stays there until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| sck | input | 1 | Serial clock from the tool, asynchronous |
| sdi | input | 1 | Serial data in, sampled on rising `sck` |
| sdo | output | 1 | Serial data out, updated on falling `sck` |
| acc_req | input | 1 | Core access request pulse |
| acc_kind | input | 2 | 0 fetch, 1 data read, 2/3 data write |
| acc_wdata | input | DW | Word to send to the tool on a write |
| irq_pend | input | 1 | Core interrupt pending, captured at request |
| busy | output | 1 | A request is outstanding |
| done | output | 1 | One-cycle pulse: a frame was received |
| seq_err | output | 1 | Kind mismatch, valid with `done` |
| rx_word | output | DW | Received payload |
| rx_kind | output | 2 | 0 instruction, 1 data, 2 command |

## Verification
The bench sweeps every access kind against every mode/control combination, with and without a pending interrupt. This separates correct instruction/data matching from mere frame completion, and checks that the 7-bit and 32-bit lengths both stop on the right bit. Frames follow one another, so each status code tests whether the previous frame's error is carried into the next one, and whether the interrupt flag takes priority over the access kind. Some frames carry a second request issued while busy, with a different word, to show that it leaves the response untouched. Serial clocking with the input held high before a request shows that the port stays silent when no request is outstanding.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_READY,
        SER_MODE,
        SER_CTRL,
        SER_DATA
    } ser_state_e;

    typedef enum logic {
        CORE_IDLE,
        CORE_WAIT
    } core_state_e;

    localparam logic [1:0] KIND_INSTR = 2'd0;
    localparam logic [1:0] KIND_DATA  = 2'd1;
    localparam logic [1:0] KIND_CMD   = 2'd2;

    localparam logic [1:0] ACC_FETCH  = 2'd0;

    localparam logic [1:0] STAT_VALID  = 2'b00;
    localparam logic [1:0] STAT_SEQERR = 2'b01;
    localparam logic [1:0] STAT_IRQ    = 2'b10;
    localparam logic [1:0] STAT_NULL   = 2'b11;

endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgp_ser_fsm.sv
module dbgp_ser_fsm
    import dbgp_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 7
) (
    input  logic          sck,
    input  logic          rst_n,
    input  logic          sdi,
    output logic          sdo,
    input  logic          req_tgl,
    input  logic [DW-1:0] req_word,
    input  logic [1:0]    req_stat,
    output logic          rsp_tgl,
    output logic [DW-1:0] rsp_word,
    output logic [1:0]    rsp_kind
);
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DW - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(CW - 1);

    ser_state_e       state_q, state_d;
    logic             req_sync, req_seen, new_req, last_bit;
    logic             mode_r, ctrl_r, sdo_d;
    logic [1:0]       tx_stat;
    logic [CNT_W-1:0] cnt;
    logic [DW-1:0]    tx_word, tx_sh, rx_sh;

    dbgp_sync #(.STAGES(2)) u_req_sync (
        .clk(sck), .rst_n(rst_n), .d(req_tgl), .q(req_sync)
    );

    assign new_req  = req_sync ^ req_seen;
    assign last_bit = (cnt == (mode_r ? LAST_SHORT : LAST_LONG));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:  if (new_req) state_d = SER_READY;
            SER_READY: if (sdi)     state_d = SER_MODE;
            SER_MODE:               state_d = SER_CTRL;
            SER_CTRL:               state_d = SER_DATA;
            SER_DATA:  if (last_bit) state_d = SER_IDLE;
            default:                state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            tx_word  <= '0;
            tx_stat  <= STAT_NULL;
            tx_sh    <= '0;
            rx_sh    <= '0;
            cnt      <= '0;
            mode_r   <= 1'b0;
            ctrl_r   <= 1'b0;
            rsp_tgl  <= 1'b0;
            rsp_word <= '0;
            rsp_kind <= KIND_INSTR;
        end else begin
            unique case (state_q)
                SER_IDLE: begin
                    if (new_req) begin
                        req_seen <= req_sync;
                        tx_word  <= req_word;
                        tx_stat  <= req_stat;
                    end
                end
                SER_MODE: mode_r <= sdi;
                SER_CTRL: begin
                    ctrl_r <= sdi;
                    cnt    <= '0;
                    rx_sh  <= '0;
                    tx_sh  <= mode_r ? {tx_word[CW-1:0], {(DW-CW){1'b0}}} : tx_word;
                end
                SER_DATA: begin
                    rx_sh <= {rx_sh[DW-2:0], sdi};
                    tx_sh <= {tx_sh[DW-2:0], 1'b0};
                    cnt   <= cnt + 1'b1;
                    if (last_bit) begin
                        rsp_word <= {rx_sh[DW-2:0], sdi};
                        rsp_kind <= mode_r ? KIND_CMD : (ctrl_r ? KIND_DATA : KIND_INSTR);
                        rsp_tgl  <= ~rsp_tgl;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            SER_READY: sdo_d = 1'b1;
            SER_MODE:  sdo_d = tx_stat[1];
            SER_CTRL:  sdo_d = tx_stat[0];
            SER_DATA:  sdo_d = tx_sh[DW-1];
            default:   sdo_d = 1'b0;
        endcase
    end

    always_ff @(negedge sck or negedge rst_n) begin
        if (!rst_n) sdo <= 1'b0;
        else        sdo <= sdo_d;
    end
endmodule

// File: rtl/dbgp_core_if.sv
module dbgp_core_if
    import dbgp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_req,
    input  logic [1:0]    acc_kind,
    input  logic [DW-1:0] acc_wdata,
    input  logic          irq_pend,
    output logic          busy,
    output logic          done,
    output logic          seq_err,
    output logic [DW-1:0] rx_word,
    output logic [1:0]    rx_kind,
    output logic          req_tgl,
    output logic [DW-1:0] req_word,
    output logic [1:0]    req_stat,
    input  logic          rsp_tgl,
    input  logic [DW-1:0] rsp_word,
    input  logic [1:0]    rsp_kind
);
    core_state_e state_q, state_d;
    logic rsp_sync, rsp_seen, rsp_evt, accept, finish;
    logic expect_data, err_last, kind_err, is_write;

    dbgp_sync #(.STAGES(2)) u_rsp_sync (
        .clk(clk), .rst_n(rst_n), .d(rsp_tgl), .q(rsp_sync)
    );

    assign rsp_evt  = rsp_sync ^ rsp_seen;
    assign accept   = (state_q == CORE_IDLE) && acc_req;
    assign finish   = (state_q == CORE_WAIT) && rsp_evt;
    assign is_write = acc_kind[1];
    assign kind_err = (rsp_kind != KIND_CMD) && ((rsp_kind == KIND_DATA) != expect_data);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_IDLE: if (acc_req) state_d = CORE_WAIT;
            CORE_WAIT: if (rsp_evt) state_d = CORE_IDLE;
            default:                state_d = CORE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CORE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_seen    <= 1'b0;
            req_tgl     <= 1'b0;
            req_word    <= '0;
            req_stat    <= STAT_NULL;
            expect_data <= 1'b0;
            err_last    <= 1'b0;
            done        <= 1'b0;
            seq_err     <= 1'b0;
            rx_word     <= '0;
            rx_kind     <= KIND_INSTR;
        end else begin
            rsp_seen <= rsp_sync;
            done     <= finish;
            seq_err  <= finish && kind_err;
            if (accept) begin
                req_tgl     <= ~req_tgl;
                req_word    <= is_write ? acc_wdata : '0;
                expect_data <= (acc_kind != ACC_FETCH);
                if (err_last)      req_stat <= STAT_SEQERR;
                else if (irq_pend) req_stat <= STAT_IRQ;
                else if (is_write) req_stat <= STAT_VALID;
                else               req_stat <= STAT_NULL;
            end
            if (finish) begin
                rx_word  <= rsp_word;
                rx_kind  <= rsp_kind;
                err_last <= kind_err;
            end
        end
    end

    always_comb begin
        busy = (state_q == CORE_WAIT);
    end
endmodule

// File: rtl/dbgp_port.sv
module dbgp_port
    import dbgp_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          sdi,
    output logic          sdo,
    input  logic          acc_req,
    input  logic [1:0]    acc_kind,
    input  logic [DW-1:0] acc_wdata,
    input  logic          irq_pend,
    output logic          busy,
    output logic          done,
    output logic          seq_err,
    output logic [DW-1:0] rx_word,
    output logic [1:0]    rx_kind
);
    logic          req_tgl, rsp_tgl;
    logic [DW-1:0] req_word, rsp_word;
    logic [1:0]    req_stat, rsp_kind;

    dbgp_core_if #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n),
        .acc_req(acc_req), .acc_kind(acc_kind), .acc_wdata(acc_wdata), .irq_pend(irq_pend),
        .busy(busy), .done(done), .seq_err(seq_err), .rx_word(rx_word), .rx_kind(rx_kind),
        .req_tgl(req_tgl), .req_word(req_word), .req_stat(req_stat),
        .rsp_tgl(rsp_tgl), .rsp_word(rsp_word), .rsp_kind(rsp_kind)
    );

    dbgp_ser_fsm #(.DW(DW), .CW(CW)) u_ser (
        .sck(sck), .rst_n(rst_n), .sdi(sdi), .sdo(sdo),
        .req_tgl(req_tgl), .req_word(req_word), .req_stat(req_stat),
        .rsp_tgl(rsp_tgl), .rsp_word(rsp_word), .rsp_kind(rsp_kind)
    );
endmodule

// File: rtl/dbgp_port_chk.sv
module dbgp_port_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          seq_err,
    input logic          req_tgl,
    input logic          rsp_tgl,
    input logic [DW-1:0] req_word
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    seq_err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> done);

    // R9
    busy_ends_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(req_word) && $stable(req_tgl)));

    // R2
    rsp_only_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_tgl) |-> busy);
endmodule

bind dbgp_port dbgp_port_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .seq_err(seq_err),
    .req_tgl(req_tgl), .rsp_tgl(rsp_tgl), .req_word(req_word)
);

// File: tb/sim_dbgp_port.sv
module sim_dbgp_port;
    logic        clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic        acc_req = 1'b0, irq_pend = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [31:0] acc_wdata = '0;
    logic        sdo, busy, done, seq_err;
    logic [31:0] rx_word;
    logic [1:0]  rx_kind;

    int tests = 0, fails = 0;
    int done_cnt = 0;
    logic [31:0] last_word;
    logic [1:0]  last_kind;
    logic        last_err;
    bit          prev_err = 1'b0;

    always #5 clk = ~clk;

    dbgp_port u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sdo(sdo),
        .acc_req(acc_req), .acc_kind(acc_kind), .acc_wdata(acc_wdata), .irq_pend(irq_pend),
        .busy(busy), .done(done), .seq_err(seq_err), .rx_word(rx_word), .rx_kind(rx_kind)
    );

    always @(negedge clk) begin
        if (done) begin
            done_cnt  <= done_cnt + 1;
            last_word <= rx_word;
            last_kind <= rx_kind;
            last_err  <= seq_err;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic sck_cycle(input logic din, output logic dout);
        sdi = din;
        #12;
        dout = sdo;
        sck = 1'b1;
        #23;
        sck = 1'b0;
        #11;
    endtask

    task automatic core_req(input logic [1:0] kind, input logic [31:0] wdata, input logic irq);
        @(negedge clk);
        acc_kind = kind; acc_wdata = wdata; irq_pend = irq; acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic run_frame(input logic [1:0] kind, input logic [31:0] wdata, input logic irq,
                             input logic mode, input logic ctrl, input logic [31:0] payload,
                             input bit extra);
        logic d, s0, s1;
        int len, base;
        logic [31:0] mask, got, exp_resp;
        logic [1:0] exp_stat, exp_kind;
        bit exp_err;
        len      = mode ? 7 : 32;
        mask     = mode ? 32'h7F : 32'hFFFF_FFFF;
        exp_stat = prev_err ? 2'b01 : (irq ? 2'b10 : (kind[1] ? 2'b00 : 2'b11));
        exp_resp = (kind[1] ? wdata : 32'h0) & mask;
        exp_kind = mode ? 2'd2 : {1'b0, ctrl};
        exp_err  = !mode && (ctrl != (kind != 2'd0));
        base     = done_cnt;
        got      = '0;

        core_req(kind, wdata, irq);
        if (extra) core_req(2'd2, ~wdata, 1'b0);  // R8: ignored while busy
        d = 1'b0;
        for (int w = 0; w < 10 && !d; w++) sck_cycle(1'b0, d);
        check("R2", "ready bit", {31'b0, d}, 32'd1);
        sck_cycle(1'b1, d);
        check("R2", "ready held at start", {31'b0, d}, 32'd1);
        sck_cycle(mode, s0);
        sck_cycle(ctrl, s1);
        check("R5", "status code", {30'b0, s0, s1}, {30'b0, exp_stat});
        for (int i = len - 1; i >= 0; i--) begin
            sck_cycle(payload[i], d);
            got[i] = d;
        end
        check("R4", "response bits", got, exp_resp);
        repeat (6) @(negedge clk);
        check("R6", "one done pulse", done_cnt, base + 1);
        check("R3", "received word", last_word, payload & mask);
        check("R6", "received kind", {30'b0, last_kind}, {30'b0, exp_kind});
        check("R7", "sequence error", {31'b0, last_err}, {31'b0, exp_err});
        check("R9", "busy cleared", {31'b0, busy}, 32'd0);
        sck_cycle(1'b1, d);
        check("R9", "sdo low after frame", {31'b0, d}, 32'd0);
        prev_err = exp_err;
    endtask

    initial begin
        #2_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic d;
        int idx;
        #23;
        check("R1", "sdo after reset", {31'b0, sdo}, 32'd0);
        check("R1", "busy/done/seq_err after reset", {29'b0, busy, done, seq_err}, 32'd0);
        rst_n = 1'b1;
        #20;
        for (int k = 0; k < 5; k++) begin
            sck_cycle(1'b1, d);
            check("R2", "silent without request", {31'b0, d}, 32'd0);
        end
        repeat (6) @(negedge clk);
        check("R2", "no frame without request", done_cnt, 0);

        idx = 0;
        for (int kind = 0; kind < 3; kind++)
            for (int mode = 0; mode < 2; mode++)
                for (int ctrl = 0; ctrl < 2; ctrl++)
                    for (int irq = 0; irq < 2; irq++) begin
                        run_frame(2'(kind), 32'hA5C3_0F1E ^ (32'(idx) * 32'h0101_0107), 1'(irq),
                                  1'(mode), 1'(ctrl), 32'h9E37_79B9 * 32'(idx + 3), (idx % 5) == 0);
                        idx++;
                    end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule